// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block produces the word address used to access a memory array during a four-beat burst. A single control input either captures a fresh external address or moves the burst forward by one beat. Only the two lowest address bits are sequenced. The bits above them keep the value captured at load time for the whole burst.

The beat order is chosen when the address is loaded. In linear order the low bits count up modulo four from the starting word. In interleaved order the low bits are the starting word XORed with the beat number. A suspend input freezes every register. A select input must be high for a load to take effect.

The output comes straight from registers and a small mapping stage. It therefore changes on the clock edge that follows the controlling inputs.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, `word_addr` is 0, the beat number is 0 and the order is linear.
- R2: On a rising edge with `suspend`=0, `advance`=0 and `sel`=1, the external address is captured, and from that edge `word_addr` equals `ext_addr`.
- R3: On a rising edge with `suspend`=0 and `advance`=1, the burst moves by exactly one beat, so one load followed by three advances yields four distinct word addresses.
- R4: With linear order (`interleave`=0 at load), the low two bits of `word_addr` at beat k equal (start + k) mod 4. For example, start 2 gives 2,3,0,1 and start 3 gives 3,0,1,2.
- R5: With interleaved order (`interleave`=1 at load), the low two bits at beat k equal start XOR k. For example, start 1 gives 1,0,3,2 and start 3 gives 3,2,1,0.
- R6: Bits above bit 1 of `word_addr` stay at the loaded value throughout the burst, including across wrap.
- R7: An advance after the fourth beat returns the low bits to the starting word, and the sequence then repeats.
- R8: On a rising edge with `suspend`=1, all state holds and `word_addr` is unchanged, whatever `advance`, `sel`, `interleave` and `ext_addr` are.
- R9: On a rising edge with `advance`=0 and `sel`=0, no load occurs and `word_addr` is unchanged.
- R10: `interleave` is sampled only on a load edge. Changing it during a burst does not alter that burst's order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| suspend | input | 1 | 1 = hold all state this edge |
| advance | input | 1 | 0 = load request, 1 = step to next beat |
| sel | input | 1 | Load qualifier; a load needs 1 |
| interleave | input | 1 | Order for the next load: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W (20) | External word address captured on load |
| word_addr | output | ADDR_W (20) | Current array word address |

## Verification
The clocked assertions assume that `suspend`, `advance`, `sel` and `interleave` are known 0/1 values at every sampled rising edge after reset. They also assume that `ext_addr` is known whenever a load is requested. Their `$past` references are only meaningful under those conditions. The stimulus meets this by driving every input to a defined value on each falling edge, starting before reset is released. During reset it holds the controls at a non-loading, non-advancing value.

// File: rtl/burst_pkg.sv
package burst_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_LOAD = 2'd1,
    ACT_STEP = 2'd2
  } burst_act_e;

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_pkg::*;
(
  input  logic       suspend,
  input  logic       advance,
  input  logic       sel,
  output burst_act_e act
);

  always_comb begin
    act = ACT_HOLD;
    if (!suspend) begin
      if (advance) begin
        act = ACT_STEP;
      end else if (sel) begin
        act = ACT_LOAD;
      end
    end
  end

endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  burst_act_e        act,
  input  logic [BEAT_W-1:0] start_in,
  input  logic              order_in,
  output logic [BEAT_W-1:0] start_q,
  output logic [BEAT_W-1:0] beat_q,
  output burst_order_e      order_q
);

  localparam logic [BEAT_W-1:0] BEAT_ONE = BEAT_W'(1);

  logic [BEAT_W-1:0] start_d;
  logic [BEAT_W-1:0] beat_d;
  burst_order_e      order_d;

  always_comb begin
    start_d = start_q;
    beat_d  = beat_q;
    order_d = order_q;
    case (act)
      ACT_LOAD: begin
        start_d = start_in;
        beat_d  = '0;
        order_d = burst_order_e'(order_in);
      end
      ACT_STEP: begin
        beat_d = beat_q + BEAT_ONE;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      beat_q  <= '0;
      order_q <= ORD_LINEAR;
    end else begin
      start_q <= start_d;
      beat_q  <= beat_d;
      order_q <= order_d;
    end
  end

  assert_step_one_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_STEP) |=> (beat_q == $past(beat_q) + BEAT_ONE));

  assert_load_clears_beat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (act == ACT_LOAD) |=> (beat_q == '0));

  assert_order_only_on_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (act != ACT_LOAD) |=> $stable(order_q));

endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      order,
  output logic [BEAT_W-1:0] offs
);

  logic [BEAT_W-1:0] lin_offs;
  logic [BEAT_W-1:0] xor_offs;

  assign lin_offs = start + beat;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor_bit
    assign xor_offs[b] = start[b] ^ beat[b];
  end

  always_comb begin
    offs = (order == ORD_XOR) ? xor_offs : lin_offs;
  end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
  import burst_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              suspend,
  input  logic              advance,
  input  logic              sel,
  input  logic              interleave,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] word_addr
);

  localparam int HI_W = ADDR_W - BEAT_W;

  burst_act_e        act;
  logic [BEAT_W-1:0] start_q;
  logic [BEAT_W-1:0] beat_q;
  burst_order_e      order_q;
  logic [BEAT_W-1:0] offs;
  logic [HI_W-1:0]   hi_d;
  logic [HI_W-1:0]   hi_q;

  burst_seq_ctrl u_ctrl (
    .suspend (suspend),
    .advance (advance),
    .sel     (sel),
    .act     (act)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .act      (act),
    .start_in (ext_addr[BEAT_W-1:0]),
    .order_in (interleave),
    .start_q  (start_q),
    .beat_q   (beat_q),
    .order_q  (order_q)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .start (start_q),
    .beat  (beat_q),
    .order (order_q),
    .offs  (offs)
  );

  always_comb begin
    hi_d = hi_q;
    if (act == ACT_LOAD) begin
      hi_d = ext_addr[ADDR_W-1:BEAT_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
    end else begin
      hi_q <= hi_d;
    end
  end

  assign word_addr = {hi_q, offs};

  assert_load_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !advance && sel) |=> (word_addr == $past(ext_addr)));

  assert_suspend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    suspend |=> $stable(word_addr));

  assert_unselected_load_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && !advance && !sel) |=> $stable(word_addr));

  assert_upper_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && advance) |=> (word_addr[ADDR_W-1:BEAT_W] == $past(word_addr[ADDR_W-1:BEAT_W])));

  assert_linear_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!suspend && advance && order_q == ORD_LINEAR)
      |=> (word_addr[BEAT_W-1:0] == $past(word_addr[BEAT_W-1:0]) + BEAT_W'(1)));

  assert_xor_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (order_q == ORD_XOR) |-> ((word_addr[BEAT_W-1:0] ^ start_q) == beat_q));

endmodule

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;

  localparam int AW = 20;

  typedef struct {
    logic [AW-1:0] exp;
    string         req;
  } item_t;

  logic          clk;
  logic          rst_n;
  logic          suspend;
  logic          advance;
  logic          sel;
  logic          interleave;
  logic [AW-1:0] ext_addr;
  logic [AW-1:0] word_addr;

  int total = 0;
  int bad   = 0;
  item_t sb_q[$];

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_k    = 2'd0;
  logic          m_ilv  = 1'b0;

  burst_addr_gen u_burst_addr_gen (
    .clk        (clk),
    .rst_n      (rst_n),
    .suspend    (suspend),
    .advance    (advance),
    .sel        (sel),
    .interleave (interleave),
    .ext_addr   (ext_addr),
    .word_addr  (word_addr)
  );

  initial begin
    clk = 1'b0;
    forever #10 clk = ~clk;
  end

  task automatic check(logic [AW-1:0] act, logic [AW-1:0] exp, string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: word_addr=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: applies one cycle of stimulus and pushes the expected result
  task automatic drive(bit adv, bit en, bit sus, bit ilv, logic [AW-1:0] a, string req);
    item_t it;
    @(negedge clk);
    advance = adv; sel = en; suspend = sus; interleave = ilv; ext_addr = a;
    if (!sus) begin
      if (!adv && en) begin
        m_base = a; m_k = 2'd0; m_ilv = ilv;
      end else if (adv) begin
        m_k = m_k + 2'd1;
      end
    end
    it.exp = {m_base[AW-1:2], m_ilv ? (m_base[1:0] ^ m_k) : (m_base[1:0] + m_k)};
    it.req = req;
    sb_q.push_back(it);
  endtask

  // monitor: mid-cycle after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(word_addr, it.exp, it.req);
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: word_addr=%h expected=drained", word_addr);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; suspend = 1'b0; advance = 1'b0; sel = 1'b0;
    interleave = 1'b0; ext_addr = '0;
    #5;
    check(word_addr, '0, "R1 reset");
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 20'hFFFFF, "R1 idle after reset");

    // linear, start 2: 2,3,0,1 then wrap
    drive(1'b0, 1'b1, 1'b0, 1'b0, 20'h12346, "R2 load linear");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R4 R3 R6 linear beat");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R7 linear wrap");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R7 linear after wrap");

    // interleaved, start 1: 1,0,3,2 then wrap
    drive(1'b0, 1'b1, 1'b0, 1'b1, 20'hABCD1, "R2 load interleaved");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R5 R6 interleaved beat");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R7 interleaved wrap");

    // interleaved start 2 and 3, linear start 3
    drive(1'b0, 1'b1, 1'b0, 1'b1, 20'h55552, "R2 load xor start 2");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h0, "R5 xor start 2");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 20'h00003, "R2 load xor start 3");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h0, "R5 xor start 3");
    drive(1'b0, 1'b1, 1'b0, 1'b0, 20'hFFFFF, "R2 load linear start 3");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R4 R6 linear start 3");

    // suspend holds during burst regardless of other inputs
    drive(1'b0, 1'b1, 1'b0, 1'b0, 20'h3C3C1, "R2 load before suspend");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R3 step before suspend");
    drive(1'b1, 1'b1, 1'b1, 1'b1, 20'h0, "R8 suspend with advance");
    drive(1'b0, 1'b1, 1'b1, 1'b1, 20'h99999, "R8 suspend with load");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R8 resume step");

    // load with select low is ignored
    drive(1'b0, 1'b0, 1'b0, 1'b1, 20'h77777, "R9 unselected load");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 20'h11110, "R9 unselected load again");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R9 burst continues");

    // order select changed mid-burst has no effect
    drive(1'b0, 1'b1, 1'b0, 1'b0, 20'h40001, "R2 load linear start 1");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b1, 20'h0, "R10 order fixed linear");
    drive(1'b0, 1'b1, 1'b0, 1'b1, 20'h40001, "R2 load xor start 1");
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 20'h0, "R10 order fixed xor");

    @(negedge clk);
    advance = 1'b0; sel = 1'b0;
    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      total++; bad++;
      $display("FAIL scoreboard: pending=%0d expected=0", sb_q.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule